// File: doc/BRIEF.md
# Dual-Issue Dispatch Hazard Controller

This block sits between an in-order micro-op queue and the issue side of a vector back end. Each cycle it looks at the two oldest queued micro-ops and decides how many of them go out. It checks their vector sources against the destinations still held in the reorder buffer, and it checks the younger op against the older one. It also counts the register-file reads the pair would need. It then raises a valid to the reservation station of each op's execution unit and to the reorder buffer, and it returns a ready to the queue for every op that leaves.

A source whose newest pending writer in the reorder buffer has already finished takes that writer's data directly, so there is no stall. The youngest writer is found by walking backwards from the buffer's tail. The other sources are packed, in program order, onto the register-file read ports, and their data is handed back as operands. The block also tags each op with a reorder-buffer slot and computes each op's maximum vector length from its element width and group multiplier.

The decision logic is combinational, because a valid/ready exchange has to be settled in the same cycle. The clock and the active-high reset only frame the checks on that behaviour.

Top module: `dispatch_pair_ctrl`

## Requirements
- R1: Ops leave in program order: the second op (slot 1) is never issued in a cycle in which the first op (slot 0) is not issued.
- R2: An op is issued only when its execution unit's reservation-station ready and its reorder-buffer ready are both high. Issue raises exactly one reservation-station valid, at the bit given by the unit code (0 ALU, 1 permute/reduction, 2 multiply, 3 divide, 4 load-store). It also raises the reorder-buffer valid and the queue ready for that slot.
- R3: Slot 0 is not issued while any of its enabled sources matches a youngest reorder-buffer writer that is not done.
- R4: Slot 1 is held back while any of its enabled sources matches a youngest reorder-buffer writer that is not done.
- R5: Slot 1 is held back when one of its enabled sources equals slot 0's vector destination.
- R6: When the youngest matching reorder-buffer entry is done, its data becomes the operand and causes no stall. Age is counted backwards from the tail, and the count wraps.
- R7: When the pair needs more than four register-file reads in total, only slot 0 may issue. Reads are packed onto the ports in the order slot0 src1, src2, accumulator, then slot1 src1, src2, accumulator. A source that gets no port reads zero.
- R8: A destination marked scalar, whether in the reorder buffer or on slot 0, creates no hazard on a vector source.
- R9: Slot 0 is tagged with the tail index. Slot 1 gets tail+1, which wraps, unless it is marked as a reduction or compare op that is not the first of its instruction; then it reuses slot 0's tag.
- R10: The maximum vector length equals 1 shifted left by (low two multiplier bits + log2 of the register width in bytes − width code − 4 when the multiplier's top bit is set). A negative shift gives 0.
- R11: When slot 0 is absent or not issued, every valid and ready of slot 1 is low.
- R12: An enabled source with no completed reorder-buffer match takes the data of the read port it was given. A disabled source reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the checks |
| rst | input | 1 | Synchronous active-high reset |
| uq_valid_i | input | 2 | Queue op present, per slot |
| uq_ready_o | output | 2 | Op taken from queue, per slot |
| uq_unit_i | input | 2x3 | Execution unit code, per slot |
| uq_src1_idx_i | input | 2x5 | First source register |
| uq_src1_en_i | input | 2 | First source used |
| uq_src2_idx_i | input | 2x5 | Second source register |
| uq_src2_en_i | input | 2 | Second source used |
| uq_dst_idx_i | input | 2x5 | Destination register (also read as accumulator) |
| uq_acc_en_i | input | 2 | Destination is also read as a source |
| uq_sew_i | input | 2x3 | Element width code |
| uq_lmul_i | input | 2x3 | Group multiplier code |
| lead_dst_en_i | input | 1 | Slot 0 writes a destination |
| lead_dst_scalar_i | input | 1 | Slot 0 destination is scalar |
| next_shared_i | input | 1 | Slot 1 is a reduction/compare op |
| next_first_i | input | 1 | Slot 1 is the first op of its instruction |
| rs_valid_o | output | 2x5 | Reservation-station valid per slot and unit |
| rs_ready_i | input | 2x5 | Reservation-station ready per slot and unit |
| rob_valid_o | output | 2 | Reorder-buffer push valid |
| rob_ready_i | input | 2 | Reorder-buffer push ready |
| rob_tail_i | input | 3 | Next free reorder-buffer slot |
| rob_tag_o | output | 2x3 | Assigned reorder-buffer slot per op |
| rob_ent_valid_i | input | 8 | Entry occupied |
| rob_ent_done_i | input | 8 | Entry result available |
| rob_ent_scalar_i | input | 8 | Entry writes a scalar register |
| rob_ent_idx_i | input | 8x5 | Entry destination register |
| rob_ent_data_i | input | 8x32 | Entry result data |
| vrf_idx_o | output | 4x5 | Read-port register index |
| vrf_data_i | input | 4x32 | Read-port data, same cycle |
| opnd_o | output | 2x3x32 | Operands per slot: src1, src2, accumulator |
| vlmax_o | output | 2x8 | Maximum vector length per slot |

## Verification
The assertions check on every cycle that issue is in order and that no valid goes to a reservation station or buffer that is not ready. They also check that at most one unit valid is raised per slot, that a stalled or dependent op never leaves, and that an over-budget pair sends only one op. The tag step is checked on every cycle as well. Some behaviour shows only in the bench's scenarios: which reorder-buffer entry counts as youngest when the age count wraps past the tail, the operand data actually selected, the packing of reads onto the ports, and the computed vector lengths.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  localparam int SLOTS = 2;
  localparam int SRCS  = 3;

  typedef enum logic [2:0] {
    UNIT_ALU  = 3'd0,
    UNIT_PERM = 3'd1,
    UNIT_MUL  = 3'd2,
    UNIT_DIV  = 3'd3,
    UNIT_LSU  = 3'd4
  } unit_e;
endpackage

// File: rtl/dpc_rob_lookup.sv
// Finds the youngest reorder-buffer writer of one vector source.
module dpc_rob_lookup #(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic [IW-1:0]                 tail_i,
  input  logic [DEPTH-1:0]              ent_valid_i,
  input  logic [DEPTH-1:0]              ent_done_i,
  input  logic [DEPTH-1:0]              ent_scalar_i,
  input  logic [DEPTH-1:0][REG_W-1:0]   ent_idx_i,
  input  logic [DEPTH-1:0][DATA_W-1:0]  ent_data_i,
  input  logic                          src_en_i,
  input  logic [REG_W-1:0]              src_idx_i,
  output logic                          hit_o,
  output logic                          pend_o,
  output logic [DATA_W-1:0]             data_o
);
  logic [IW-1:0] ent;
  logic          found;

  // Walk from the newest entry (tail-1) back to the oldest.
  always_comb begin
    found  = 1'b0;
    pend_o = 1'b0;
    data_o = '0;
    ent    = '0;
    for (int a = 0; a < DEPTH; a++) begin
      ent = tail_i - IW'(a + 1);
      if (!found && src_en_i && ent_valid_i[ent] && !ent_scalar_i[ent] &&
          ent_idx_i[ent] == src_idx_i) begin
        found  = 1'b1;
        pend_o = !ent_done_i[ent];
        data_o = ent_data_i[ent];
      end
    end
    hit_o = found;
  end
endmodule

// File: rtl/dpc_read_alloc.sv
// Packs enabled sources onto the register-file read ports in program order.
module dpc_read_alloc #(
  parameter int PORTS  = 4,
  parameter int NSRC   = 6,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int CW    = $clog2(NSRC + 1),
  localparam int PW    = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic [NSRC-1:0]               src_en_i,
  input  logic [NSRC-1:0][REG_W-1:0]    src_idx_i,
  input  logic [PORTS-1:0][DATA_W-1:0]  vrf_data_i,
  output logic [PORTS-1:0][REG_W-1:0]   vrf_idx_o,
  output logic [NSRC-1:0][DATA_W-1:0]   src_data_o,
  output logic [CW-1:0]                 need_o
);
  logic [CW-1:0] cnt;

  always_comb begin
    vrf_idx_o  = '0;
    src_data_o = '0;
    cnt        = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (src_en_i[k]) begin
        if (cnt < CW'(PORTS)) begin
          vrf_idx_o[cnt[PW-1:0]] = src_idx_i[k];
          src_data_o[k]          = vrf_data_i[cnt[PW-1:0]];
        end
        cnt = cnt + CW'(1);
      end
    end
    need_o = cnt;
  end
endmodule

// File: rtl/dpc_issue_ctrl.sv
// Decides which of the two slots issue and drives the handshakes and tags.
module dpc_issue_ctrl #(
  parameter int NUM_UNITS = 5,
  parameter int IW        = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [1:0]                  valid_i,
  input  logic [1:0][2:0]             unit_i,
  input  logic [1:0]                  stall_i,
  input  logic                        dep_i,
  input  logic                        over_i,
  input  logic [1:0][NUM_UNITS-1:0]   rs_ready_i,
  input  logic [1:0]                  rob_ready_i,
  input  logic [IW-1:0]               tail_i,
  input  logic                        shared_i,
  input  logic                        first_i,
  output logic [1:0][NUM_UNITS-1:0]   rs_valid_o,
  output logic [1:0]                  rob_valid_o,
  output logic [1:0]                  take_o,
  output logic [1:0][IW-1:0]          tag_o
);
  logic [1:0] unit_rdy;
  logic [1:0] go;

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      unit_rdy[s] = (int'(unit_i[s]) < NUM_UNITS) ? rs_ready_i[s][unit_i[s]] : 1'b0;
    end
    go[0] = valid_i[0] & !stall_i[0] & unit_rdy[0] & rob_ready_i[0];
    go[1] = go[0] & valid_i[1] & !stall_i[1] & !dep_i & !over_i &
            unit_rdy[1] & rob_ready_i[1];
    for (int s = 0; s < 2; s++) begin
      rs_valid_o[s] = go[s] ? (NUM_UNITS'(1) << unit_i[s]) : '0;
    end
    rob_valid_o = go;
    take_o      = go;
    tag_o[0]    = tail_i;
    tag_o[1]    = (shared_i && !first_i) ? tail_i : tail_i + IW'(1);
  end

  AST_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
    rob_valid_o[1] |-> rob_valid_o[0]); // R1
  AST_UNIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rs_valid_o[0]) && $onehot0(rs_valid_o[1])); // R2
  AST_RS_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    !(|(rs_valid_o[0] & ~rs_ready_i[0])) && !(|(rs_valid_o[1] & ~rs_ready_i[1]))); // R2
  AST_ROB_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (rob_valid_o[0] |-> rob_ready_i[0]) and (rob_valid_o[1] |-> rob_ready_i[1])); // R2
  AST_LEAD_STALL: assert property (@(posedge clk) disable iff (rst)
    stall_i[0] |-> !rob_valid_o[0]); // R3
  AST_NEXT_ROB_HOLD: assert property (@(posedge clk) disable iff (rst)
    stall_i[1] |-> !rob_valid_o[1]); // R4
  AST_NEXT_DEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    dep_i |-> !rob_valid_o[1]); // R5
  AST_READ_BUDGET: assert property (@(posedge clk) disable iff (rst)
    over_i |-> !rob_valid_o[1]); // R7
  AST_NEXT_SILENT: assert property (@(posedge clk) disable iff (rst)
    !take_o[0] |-> (rs_valid_o[1] == '0) && !take_o[1]); // R11
endmodule

// File: rtl/dispatch_pair_ctrl.sv
module dispatch_pair_ctrl
  import dpc_pkg::*;
#(
  parameter int ROB_DEPTH = 8,
  parameter int REG_W     = 5,
  parameter int DATA_W    = 32,
  parameter int VRF_PORTS = 4,
  parameter int VLENB     = 16,
  parameter int NUM_UNITS = 5,
  localparam int IW       = $clog2(ROB_DEPTH),
  localparam int VLW      = $clog2(VLENB) + 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [1:0]                        uq_valid_i,
  output logic [1:0]                        uq_ready_o,
  input  logic [1:0][2:0]                   uq_unit_i,
  input  logic [1:0][REG_W-1:0]             uq_src1_idx_i,
  input  logic [1:0]                        uq_src1_en_i,
  input  logic [1:0][REG_W-1:0]             uq_src2_idx_i,
  input  logic [1:0]                        uq_src2_en_i,
  input  logic [1:0][REG_W-1:0]             uq_dst_idx_i,
  input  logic [1:0]                        uq_acc_en_i,
  input  logic [1:0][2:0]                   uq_sew_i,
  input  logic [1:0][2:0]                   uq_lmul_i,
  input  logic                              lead_dst_en_i,
  input  logic                              lead_dst_scalar_i,
  input  logic                              next_shared_i,
  input  logic                              next_first_i,
  output logic [1:0][NUM_UNITS-1:0]         rs_valid_o,
  input  logic [1:0][NUM_UNITS-1:0]         rs_ready_i,
  output logic [1:0]                        rob_valid_o,
  input  logic [1:0]                        rob_ready_i,
  input  logic [IW-1:0]                     rob_tail_i,
  output logic [1:0][IW-1:0]                rob_tag_o,
  input  logic [ROB_DEPTH-1:0]              rob_ent_valid_i,
  input  logic [ROB_DEPTH-1:0]              rob_ent_done_i,
  input  logic [ROB_DEPTH-1:0]              rob_ent_scalar_i,
  input  logic [ROB_DEPTH-1:0][REG_W-1:0]   rob_ent_idx_i,
  input  logic [ROB_DEPTH-1:0][DATA_W-1:0]  rob_ent_data_i,
  output logic [VRF_PORTS-1:0][REG_W-1:0]   vrf_idx_o,
  input  logic [VRF_PORTS-1:0][DATA_W-1:0]  vrf_data_i,
  output logic [1:0][SRCS-1:0][DATA_W-1:0]  opnd_o,
  output logic [1:0][VLW-1:0]               vlmax_o
);
  localparam int NSRC = SLOTS * SRCS;
  localparam int CW   = $clog2(NSRC + 1);

  logic [NSRC-1:0]              src_en;
  logic [NSRC-1:0][REG_W-1:0]   src_idx;
  logic [NSRC-1:0]              hit;
  logic [NSRC-1:0]              pend;
  logic [NSRC-1:0][DATA_W-1:0]  fwd;
  logic [NSRC-1:0][DATA_W-1:0]  port_data;
  logic [CW-1:0]                need;
  logic [1:0]                   stall;
  logic                         dep;
  logic                         over;

  // Source list in program order: per slot src1, src2, accumulator.
  for (genvar s = 0; s < SLOTS; s++) begin : g_src
    assign src_en[s*SRCS+0]  = uq_valid_i[s] & uq_src1_en_i[s];
    assign src_idx[s*SRCS+0] = uq_src1_idx_i[s];
    assign src_en[s*SRCS+1]  = uq_valid_i[s] & uq_src2_en_i[s];
    assign src_idx[s*SRCS+1] = uq_src2_idx_i[s];
    assign src_en[s*SRCS+2]  = uq_valid_i[s] & uq_acc_en_i[s];
    assign src_idx[s*SRCS+2] = uq_dst_idx_i[s];
    assign stall[s]          = |pend[s*SRCS +: SRCS];
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_look
    dpc_rob_lookup #(
      .DEPTH  (ROB_DEPTH),
      .REG_W  (REG_W),
      .DATA_W (DATA_W)
    ) u_look (
      .tail_i       (rob_tail_i),
      .ent_valid_i  (rob_ent_valid_i),
      .ent_done_i   (rob_ent_done_i),
      .ent_scalar_i (rob_ent_scalar_i),
      .ent_idx_i    (rob_ent_idx_i),
      .ent_data_i   (rob_ent_data_i),
      .src_en_i     (src_en[k]),
      .src_idx_i    (src_idx[k]),
      .hit_o        (hit[k]),
      .pend_o       (pend[k]),
      .data_o       (fwd[k])
    );
    assign opnd_o[k/SRCS][k%SRCS] = (hit[k] && !pend[k]) ? fwd[k] : port_data[k];
  end

  dpc_read_alloc #(
    .PORTS  (VRF_PORTS),
    .NSRC   (NSRC),
    .REG_W  (REG_W),
    .DATA_W (DATA_W)
  ) u_alloc (
    .src_en_i   (src_en),
    .src_idx_i  (src_idx),
    .vrf_data_i (vrf_data_i),
    .vrf_idx_o  (vrf_idx_o),
    .src_data_o (port_data),
    .need_o     (need)
  );

  assign over = need > CW'(VRF_PORTS);

  // Slot 1 reading slot 0's vector destination.
  always_comb begin
    dep = 1'b0;
    for (int j = 0; j < SRCS; j++) begin
      if (src_en[SRCS+j] && src_idx[SRCS+j] == uq_dst_idx_i[0]) dep = 1'b1;
    end
    dep = dep & uq_valid_i[0] & lead_dst_en_i & !lead_dst_scalar_i;
  end

  dpc_issue_ctrl #(
    .NUM_UNITS (NUM_UNITS),
    .IW        (IW)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .valid_i     (uq_valid_i),
    .unit_i      (uq_unit_i),
    .stall_i     (stall),
    .dep_i       (dep),
    .over_i      (over),
    .rs_ready_i  (rs_ready_i),
    .rob_ready_i (rob_ready_i),
    .tail_i      (rob_tail_i),
    .shared_i    (next_shared_i),
    .first_i     (next_first_i),
    .rs_valid_o  (rs_valid_o),
    .rob_valid_o (rob_valid_o),
    .take_o      (uq_ready_o),
    .tag_o       (rob_tag_o)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_vl
    int sh;
    always_comb begin
      sh = int'(uq_lmul_i[s][1:0]) + $clog2(VLENB) - int'(uq_sew_i[s]) -
           (uq_lmul_i[s][2] ? 4 : 0);
      vlmax_o[s] = (sh < 0 || sh >= VLW) ? '0 : (VLW'(1) << sh);
    end
  end

  AST_NEXT_TAG_STEP: assert property (@(posedge clk) disable iff (rst)
    (rob_valid_o[1] && !next_shared_i) |-> rob_tag_o[1] == rob_tail_i + IW'(1)); // R9
endmodule

// File: tb/dispatch_pair_ctrl_bench.sv
`timescale 1ns/1ps
module dispatch_pair_ctrl_bench;
  import dpc_pkg::*;

  localparam int D = 8, RW = 5, DW = 32, NP = 4, NU = 5, IW = 3, VLW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [1:0]              uq_valid_i, uq_ready_o, uq_src1_en_i, uq_src2_en_i, uq_acc_en_i;
  logic [1:0][2:0]         uq_unit_i, uq_sew_i, uq_lmul_i;
  logic [1:0][RW-1:0]      uq_src1_idx_i, uq_src2_idx_i, uq_dst_idx_i;
  logic                    lead_dst_en_i, lead_dst_scalar_i, next_shared_i, next_first_i;
  logic [1:0][NU-1:0]      rs_valid_o, rs_ready_i;
  logic [1:0]              rob_valid_o, rob_ready_i;
  logic [IW-1:0]           rob_tail_i;
  logic [1:0][IW-1:0]      rob_tag_o;
  logic [D-1:0]            rob_ent_valid_i, rob_ent_done_i, rob_ent_scalar_i;
  logic [D-1:0][RW-1:0]    rob_ent_idx_i;
  logic [D-1:0][DW-1:0]    rob_ent_data_i;
  logic [NP-1:0][RW-1:0]   vrf_idx_o;
  logic [NP-1:0][DW-1:0]   vrf_data_i;
  logic [1:0][2:0][DW-1:0] opnd_o;
  logic [1:0][VLW-1:0]     vlmax_o;

  dispatch_pair_ctrl u_dispatch_pair_ctrl (.*);

  typedef struct packed {
    logic [1:0][NU-1:0]      rs;
    logic [1:0]              rob;
    logic [1:0][IW-1:0]      tag;
    logic [NP-1:0][RW-1:0]   vidx;
    logic [1:0][2:0][DW-1:0] op;
    logic [1:0][VLW-1:0]     vl;
  } exp_t;

  exp_t  e;
  exp_t  cur;
  string cur_r;
  exp_t  q[$];
  string rq[$];
  int    n_chk = 0;
  int    n_fail = 0;

  function automatic logic [DW-1:0] pa(int p); return 32'hA000_0000 + DW'(p); endfunction
  function automatic logic [DW-1:0] eb(int x); return 32'hB000_0000 + DW'(x); endfunction

  task automatic chk(string req, string what, logic [191:0] act, logic [191:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: compare one expected item per cycle, away from the edge.
  always @(posedge clk) begin
    #1;
    if (q.size() != 0) begin
      cur   = q.pop_front();
      cur_r = rq.pop_front();
      chk(cur_r, "valids", 192'({rs_valid_o, rob_valid_o, uq_ready_o}), 192'({cur.rs, cur.rob, cur.rob}));
      chk(cur_r, "tags",   192'(rob_tag_o), 192'(cur.tag));
      chk(cur_r, "ports",  192'(vrf_idx_o), 192'(cur.vidx));
      chk(cur_r, "opnds",  opnd_o, cur.op);
      chk(cur_r, "vlmax",  192'(vlmax_o), 192'(cur.vl));
    end
  end

  task automatic push(string req);
    q.push_back(e);
    rq.push_back(req);
  endtask

  task automatic clr();
    @(negedge clk);
    uq_valid_i = '0; uq_unit_i = '0; uq_sew_i = '0; uq_lmul_i = '0;
    uq_src1_idx_i = '0; uq_src2_idx_i = '0; uq_dst_idx_i = '0;
    uq_src1_en_i = '0; uq_src2_en_i = '0; uq_acc_en_i = '0;
    lead_dst_en_i = 1'b0; lead_dst_scalar_i = 1'b0; next_shared_i = 1'b0; next_first_i = 1'b0;
    rs_ready_i = '1; rob_ready_i = 2'b11; rob_tail_i = '0;
    rob_ent_valid_i = '0; rob_ent_done_i = '0; rob_ent_scalar_i = '0; rob_ent_idx_i = '0;
    e = '0;
    e.tag[1] = 3'd1;
    e.vl = {8'd16, 8'd16};
  endtask

  task automatic uop(int s, unit_e u, int a, bit ae, int b, bit be, int d);
    uq_valid_i[s] = 1'b1; uq_unit_i[s] = u;
    uq_src1_idx_i[s] = RW'(a); uq_src1_en_i[s] = ae;
    uq_src2_idx_i[s] = RW'(b); uq_src2_en_i[s] = be;
    uq_dst_idx_i[s] = RW'(d);
  endtask

  task automatic ent(int x, int idx, bit done, bit scalar);
    rob_ent_valid_i[x] = 1'b1; rob_ent_idx_i[x] = RW'(idx);
    rob_ent_done_i[x] = done; rob_ent_scalar_i[x] = scalar;
  endtask

  // Common pair: slot0 ALU reads 1,2 writes 10; slot1 MUL reads 3.
  task automatic base_pair();
    uop(0, UNIT_ALU, 1, 1, 2, 1, 10); lead_dst_en_i = 1'b1;
    uop(1, UNIT_MUL, 3, 1, 0, 0, 11);
    e.vidx[0] = 5'd1; e.vidx[1] = 5'd2; e.vidx[2] = 5'd3;
    e.op[0][0] = pa(0); e.op[0][1] = pa(1); e.op[1][0] = pa(2);
  endtask

  task automatic both_go();
    e.rob = 2'b11; e.rs[0] = 5'b00001; e.rs[1] = 5'b00100;
  endtask

  initial begin
    for (int p = 0; p < NP; p++) vrf_data_i[p] = pa(p);
    for (int x = 0; x < D; x++) rob_ent_data_i[x] = eb(x);
    clr(); push("R2"); // reset state: nothing issues
    clr(); push("R2");
    rst = 1'b0;
    clr(); push("R2");                               // idle after reset
    clr(); base_pair(); both_go(); push("R1");       // plain pair
    clr(); base_pair(); e.rob = 2'b11; e.rs[0] = 5'b00001; e.rs[1] = 5'b00100; push("R12");
    clr(); base_pair(); rob_tail_i = 3'd6; ent(5, 1, 0, 0);
           e.tag[0] = 3'd6; e.tag[1] = 3'd7; push("R3");   // slot0 stalls, slot1 silent
    clr(); base_pair(); ent(2, 3, 0, 0); e.rob = 2'b01; e.rs[0] = 5'b00001; push("R4");
    clr(); uop(0, UNIT_ALU, 1, 1, 2, 1, 10); lead_dst_en_i = 1'b1;
           uop(1, UNIT_MUL, 0, 0, 10, 1, 11);
           e.vidx[0] = 5'd1; e.vidx[1] = 5'd2; e.vidx[2] = 5'd10;
           e.op[0][0] = pa(0); e.op[0][1] = pa(1); e.op[1][1] = pa(2);
           e.rob = 2'b01; e.rs[0] = 5'b00001; push("R5");
    clr(); uop(0, UNIT_ALU, 1, 1, 2, 1, 10); lead_dst_en_i = 1'b1; lead_dst_scalar_i = 1'b1;
           uop(1, UNIT_MUL, 0, 0, 10, 1, 11); ent(7, 1, 0, 1);
           e.vidx[0] = 5'd1; e.vidx[1] = 5'd2; e.vidx[2] = 5'd10;
           e.op[0][0] = pa(0); e.op[0][1] = pa(1); e.op[1][1] = pa(2);
           both_go(); push("R8");
    clr(); base_pair(); ent(5, 1, 1, 0); ent(3, 1, 0, 0); ent(4, 3, 1, 0);
           e.op[0][0] = eb(5); e.op[1][0] = eb(4); both_go(); push("R6");   // youngest done wins
    clr(); base_pair(); rob_tail_i = 3'd2; ent(1, 1, 1, 0); ent(7, 1, 0, 0);
           e.tag[0] = 3'd2; e.tag[1] = 3'd3; e.op[0][0] = eb(1); both_go(); push("R6");
    clr(); base_pair(); rob_tail_i = 3'd2; ent(1, 1, 0, 0); ent(7, 1, 1, 0);
           e.tag[0] = 3'd2; e.tag[1] = 3'd3; push("R3");                    // wrap: young pending
    clr(); uop(0, UNIT_ALU, 1, 1, 2, 1, 10); lead_dst_en_i = 1'b1; uq_acc_en_i[0] = 1'b1;
           uop(1, UNIT_MUL, 3, 1, 4, 1, 11);
           e.vidx[0] = 5'd1; e.vidx[1] = 5'd2; e.vidx[2] = 5'd10; e.vidx[3] = 5'd3;
           e.op[0][0] = pa(0); e.op[0][1] = pa(1); e.op[0][2] = pa(2); e.op[1][0] = pa(3);
           e.rob = 2'b01; e.rs[0] = 5'b00001; push("R7");                   // five reads
    clr(); uop(0, UNIT_ALU, 1, 1, 2, 1, 10); lead_dst_en_i = 1'b1;
           uop(1, UNIT_MUL, 3, 1, 4, 1, 11);
           e.vidx[0] = 5'd1; e.vidx[1] = 5'd2; e.vidx[2] = 5'd3; e.vidx[3] = 5'd4;
           e.op[0][0] = pa(0); e.op[0][1] = pa(1); e.op[1][0] = pa(2); e.op[1][1] = pa(3);
           both_go(); push("R7");                                           // exactly four
    clr(); base_pair(); rs_ready_i[0][0] = 1'b0; push("R2");
    clr(); base_pair(); rob_ready_i[1] = 1'b0; e.rob = 2'b01; e.rs[0] = 5'b00001; push("R2");
    clr(); base_pair(); uq_unit_i[0] = UNIT_LSU; uq_unit_i[1] = UNIT_PERM; rs_ready_i[1][1] = 1'b0;
           e.rob = 2'b01; e.rs[0] = 5'b10000; push("R2");
    clr(); base_pair(); uq_unit_i[0] = UNIT_LSU; uq_unit_i[1] = UNIT_PERM;
           e.rob = 2'b11; e.rs[0] = 5'b10000; e.rs[1] = 5'b00010; push("R2");
    clr(); base_pair(); rob_tail_i = 3'd7; next_shared_i = 1'b1;
           e.tag[0] = 3'd7; e.tag[1] = 3'd7; both_go(); push("R9");
    clr(); base_pair(); rob_tail_i = 3'd7; next_shared_i = 1'b1; next_first_i = 1'b1;
           e.tag[0] = 3'd7; e.tag[1] = 3'd0; both_go(); push("R9");
    clr(); base_pair(); uq_lmul_i[0] = 3'd3; uq_sew_i[1] = 3'd2; uq_lmul_i[1] = 3'd7;
           e.vl[0] = 8'd128; e.vl[1] = 8'd2; both_go(); push("R10");
    clr(); base_pair(); uq_sew_i[0] = 3'd3; uq_lmul_i[0] = 3'd5; uq_sew_i[1] = 3'd1; uq_lmul_i[1] = 3'd1;
           e.vl[0] = 8'd0; e.vl[1] = 8'd16; both_go(); push("R10");
    clr(); uop(1, UNIT_MUL, 3, 1, 0, 0, 11);
           e.vidx[0] = 5'd3; e.op[1][0] = pa(0); push("R11");               // slot0 absent
    clr(); uop(0, UNIT_DIV, 0, 0, 5, 1, 12);
           e.vidx[0] = 5'd5; e.op[0][1] = pa(0); e.rob = 2'b01; e.rs[0] = 5'b01000; push("R12");
    clr();
    repeat (4) @(posedge clk);
    #2;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule